// File: doc/BRIEF.md
# Serial ADC Control-Register Port

This block is the digital slave side of a four-channel 12-bit converter's serial port. A host frames each transfer by pulling the active-low select low and then gives sixteen serial clocks. On the falling edges the block shifts a control word in, most significant bit first. At the same time it shifts the previous result out. The result is a 16-bit frame: two zero bits, the two-bit address of the converted channel, then the 12-bit sample MSB first. The sample is coded as straight binary or as twos complement, depending on the coding setting that was in force when the frame opened.

The block owns the control register and decodes it into a channel select for the analog multiplexer, an input-range flag, the coding flag and a power mode. A power sequencer follows the power mode. It turns the analog section off for full shutdown. In auto shutdown it turns the analog section off after every completed frame and wakes it at the next select assertion. A result is flagged valid only after a programmable wake-up count of system clocks. The serial clock and the select are sampled in the system clock domain, and both are taken to be already synchronised.

The frame FSM has five states. FR_IDLE goes to FR_LOAD when select falls. FR_LOAD goes to FR_WAIT at the 12th falling edge. FR_WAIT goes to FR_HOLD at the 14th. FR_HOLD goes to FR_DONE at the 16th, which is the commit point. Any state returns to FR_IDLE when select is high, and that return is the abort path. The power FSM has three states. PW_ON goes to PW_OFF when the mode is full shutdown, or when the mode is auto shutdown and a frame ends. PW_OFF goes to PW_WAKE when the mode is normal, or when the mode is auto shutdown and a frame starts. PW_WAKE goes to PW_ON when the wake count expires, and to PW_OFF if the mode is full shutdown.

Top module: `sadc_ctrl_port`

## Requirements
- R1: After reset: mux_sel = 0, pwr_mode = 2'b11 (normal), range_sel = 0, coding_sel = 0, pm_err = 0, powered = 1, ready = 1, dout_oe = 0.
- R2: The first bit shifted in (word bit 11) is a write enable. When it is 0, the frame changes no register field and no output flag.
- R3: Only the first 12 falling edges after select falls load the word. The data on falling edges 13 to 16 has no effect.
- R4: Field positions within the 12-bit word: channel address in bits 7:6 (binary, giving mux_sel 0..3), power mode in bits 5:4, range in bit 1, coding in bit 0. Bits 10, 9, 8, 3 and 2 are ignored.
- R5: A written channel address appears on mux_sel right after the 14th falling edge, and not after the 13th.
- R6: The output frame is bits 15..0 = {2'b00, address, data}. The address is the mux_sel value when select fell. Bit 15 is on dout before the first falling edge, and each falling edge advances one bit. dout_oe is low while select is high.
- R7: With coding 1 the data is the raw sample. With coding 0 it is the sample with its MSB inverted. The coding used is the one held when select fell.
- R8: A committed write with power bits 2'b00 keeps the previous pwr_mode and sets pm_err, while its other fields still load. The next committed write with a legal power code clears pm_err.
- R9: If select rises before the 16th falling edge, no field changes, and mux_sel goes back to the stored address.
- R10: With mode 2'b10 (full shutdown), powered goes low and the register keeps its fields. Writing 2'b11 raises powered at once, and ready rises WAKE_CYC clocks later.
- R11: With mode 2'b01 (auto shutdown), powered drops at the end of each completed frame. The next select fall starts the wake, and ready rises exactly WAKE_CYC clocks after the clock edge that sees select low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low frame select (synchronised) |
| sclk | input | 1 | Serial clock, idles high (synchronised) |
| din | input | 1 | Serial control data, sampled on sclk falls |
| sample | input | 12 | Raw straight-binary conversion result |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Output enable for dout (high = drive) |
| mux_sel | output | 2 | Analog multiplexer channel select |
| range_sel | output | 1 | Latched input-range flag |
| coding_sel | output | 1 | Latched coding flag (1 = straight binary) |
| pwr_mode | output | 2 | Current power mode code |
| pm_err | output | 1 | Last write carried the illegal power code |
| powered | output | 1 | Analog section powered |
| ready | output | 1 | Wake-up complete, conversion valid |

## Verification
The assertions assume that sclk and cs_n are already synchronous to clk. They also assume that no sclk fall lands in the same clock as the select fall, so the edge counter sees every serial edge exactly once. The bench drives all inputs on the falling clock edge. It holds each serial level for at least four system clocks, and it changes the select only while sclk is high, so every stimulus stays inside those assumptions. The sample input is held constant for the whole frame, because it is captured when the frame opens.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
    localparam int CW        = 12;
    localparam int DATA_W    = 12;
    localparam int ADDR_W    = 2;
    localparam int FRAME_LEN = 16;
    localparam int LOAD_LEN  = 12;
    localparam int MUX_EDGE  = 14;

    localparam int BIT_WR  = 11;
    localparam int ADDR_HI = 7;
    localparam int ADDR_LO = 6;
    localparam int PM_HI   = 5;
    localparam int PM_LO   = 4;
    localparam int BIT_RNG = 1;
    localparam int BIT_COD = 0;

    localparam logic [1:0] PM_NORMAL = 2'b11;
    localparam logic [1:0] PM_FULL   = 2'b10;
    localparam logic [1:0] PM_AUTO   = 2'b01;
    localparam logic [1:0] PM_BAD    = 2'b00;

    typedef enum logic [2:0] {FR_IDLE, FR_LOAD, FR_WAIT, FR_HOLD, FR_DONE} frame_st_t;
    typedef enum logic [1:0] {PW_OFF, PW_WAKE, PW_ON} pwr_st_t;
endpackage

// File: rtl/sadc_fmt.sv
module sadc_fmt
    import sadc_pkg::*;
#(
    parameter int FLEN = FRAME_LEN,
    parameter int AW   = ADDR_W,
    parameter int DW   = DATA_W
) (
    input  logic [DW-1:0]   raw,
    input  logic [AW-1:0]   addr,
    input  logic            straight,
    output logic [FLEN-1:0] word
);
    localparam int PAD = FLEN - AW - DW;

    logic [DW-1:0] coded;

    always_comb begin
        coded = raw;
        if (!straight) coded[DW-1] = ~raw[DW-1];
    end

    generate
        if (PAD > 0) begin : g_pad
            assign word = {{PAD{1'b0}}, addr, coded};
        end else begin : g_nopad
            assign word = {addr, coded};
        end
    endgenerate
endmodule

// File: rtl/sadc_frame.sv
module sadc_frame
    import sadc_pkg::*;
#(
    parameter int FLEN  = FRAME_LEN,
    parameter int LLEN  = LOAD_LEN,
    parameter int MEDGE = MUX_EDGE,
    parameter int W     = CW,
    localparam int CNT_W = $clog2(FLEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             din,
    input  logic [FLEN-1:0]  tx_word,
    output logic             frame_start,
    output logic             frame_end,
    output logic             sel_early,
    output logic [W-1:0]     rx_word,
    output logic [CNT_W-1:0] edge_cnt,
    output logic             dout,
    output logic             dout_oe
);
    localparam logic [CNT_W-1:0] C_LOAD = CNT_W'(LLEN - 1);
    localparam logic [CNT_W-1:0] C_MUX  = CNT_W'(MEDGE - 1);
    localparam logic [CNT_W-1:0] C_LAST = CNT_W'(FLEN - 1);
    localparam logic [CNT_W-1:0] C_FULL = CNT_W'(FLEN);

    frame_st_t       state, nxt;
    logic            sclk_q, cs_q, fall;
    logic [FLEN-1:0] tx;

    assign fall = sclk_q & ~sclk & ~cs_n;

    always_comb begin
        nxt = state;
        if (cs_n) begin
            nxt = FR_IDLE;
        end else begin
            unique case (state)
                FR_IDLE: if (cs_q)                      nxt = FR_LOAD;
                FR_LOAD: if (fall && edge_cnt == C_LOAD) nxt = FR_WAIT;
                FR_WAIT: if (fall && edge_cnt == C_MUX)  nxt = FR_HOLD;
                FR_HOLD: if (fall && edge_cnt == C_LAST) nxt = FR_DONE;
                FR_DONE: nxt = FR_DONE;
                default: nxt = FR_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= FR_IDLE;
            sclk_q   <= 1'b1;
            cs_q     <= 1'b1;
            edge_cnt <= '0;
            rx_word  <= '0;
            tx       <= '0;
        end else begin
            state  <= nxt;
            sclk_q <= sclk;
            cs_q   <= cs_n;
            if (state == FR_IDLE)
                edge_cnt <= '0;
            else if (fall && edge_cnt != C_FULL)
                edge_cnt <= edge_cnt + 1'b1;
            if (frame_start)
                rx_word <= '0;
            else if (fall && state == FR_LOAD)
                rx_word <= {rx_word[W-2:0], din};
            if (frame_start)
                tx <= tx_word;
            else if (fall && state != FR_IDLE)
                tx <= {tx[FLEN-2:0], 1'b0};
        end
    end

    always_comb begin
        frame_start = (state == FR_IDLE) & cs_q & ~cs_n;
        frame_end   = (state == FR_HOLD) & fall & (edge_cnt == C_LAST);
        sel_early   = (state == FR_HOLD);
        dout_oe     = (state != FR_IDLE);
        dout        = dout_oe & tx[FLEN-1];
    end
endmodule

// File: rtl/sadc_power.sv
module sadc_power
    import sadc_pkg::*;
#(
    parameter int WAKE_CYC = 50,
    localparam int WK_W = $clog2(WAKE_CYC + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       frame_start,
    input  logic       frame_end,
    output logic       powered,
    output logic       ready
);
    localparam logic [WK_W-1:0] WK_LAST = WK_W'(WAKE_CYC - 1);

    pwr_st_t         state, nxt;
    logic [WK_W-1:0] wcnt;

    always_comb begin
        nxt = state;
        unique case (state)
            PW_OFF: begin
                if (mode == PM_NORMAL)                     nxt = PW_WAKE;
                else if (mode == PM_AUTO && frame_start)   nxt = PW_WAKE;
            end
            PW_WAKE: begin
                if (mode == PM_FULL)                       nxt = PW_OFF;
                else if (wcnt == WK_LAST)                  nxt = PW_ON;
            end
            PW_ON: begin
                if (mode == PM_FULL)                       nxt = PW_OFF;
                else if (mode == PM_AUTO && frame_end)     nxt = PW_OFF;
            end
            default: nxt = PW_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PW_ON;
            wcnt  <= '0;
        end else begin
            state <= nxt;
            if (state != PW_WAKE) wcnt <= '0;
            else                  wcnt <= wcnt + 1'b1;
        end
    end

    always_comb begin
        powered = (state != PW_OFF);
        ready   = (state == PW_ON);
    end
endmodule

// File: rtl/sadc_ctrl_port.sv
module sadc_ctrl_port
    import sadc_pkg::*;
#(
    parameter int WAKE_CYC = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              din,
    input  logic [DATA_W-1:0] sample,
    output logic              dout,
    output logic              dout_oe,
    output logic [ADDR_W-1:0] mux_sel,
    output logic              range_sel,
    output logic              coding_sel,
    output logic [1:0]        pwr_mode,
    output logic              pm_err,
    output logic              powered,
    output logic              ready
);
    localparam int CNT_W = $clog2(FRAME_LEN + 1);

    logic [ADDR_W-1:0]    reg_addr;
    logic [1:0]           reg_pm;
    logic                 reg_rng, reg_cod, reg_err;
    logic [FRAME_LEN-1:0] tx_word;
    logic [CW-1:0]        rx_word;
    logic [CNT_W-1:0]     edge_cnt;
    logic                 frame_start, frame_end, sel_early, wr_commit;
    logic                 unused_bits;

    assign unused_bits = ^{rx_word[10:8], rx_word[3:2]};
    assign wr_commit   = frame_end & rx_word[BIT_WR];

    sadc_fmt u_fmt (
        .raw      (sample),
        .addr     (reg_addr),
        .straight (reg_cod),
        .word     (tx_word)
    );

    sadc_frame u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .sclk        (sclk),
        .din         (din),
        .tx_word     (tx_word),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .sel_early   (sel_early),
        .rx_word     (rx_word),
        .edge_cnt    (edge_cnt),
        .dout        (dout),
        .dout_oe     (dout_oe)
    );

    sadc_power #(.WAKE_CYC(WAKE_CYC)) u_power (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (reg_pm),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .powered     (powered),
        .ready       (ready)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_addr <= '0;
            reg_pm   <= PM_NORMAL;
            reg_rng  <= 1'b0;
            reg_cod  <= 1'b0;
            reg_err  <= 1'b0;
        end else if (wr_commit) begin
            reg_addr <= rx_word[ADDR_HI:ADDR_LO];
            reg_rng  <= rx_word[BIT_RNG];
            reg_cod  <= rx_word[BIT_COD];
            if (rx_word[PM_HI:PM_LO] == PM_BAD) begin
                reg_err <= 1'b1;
            end else begin
                reg_pm  <= rx_word[PM_HI:PM_LO];
                reg_err <= 1'b0;
            end
        end
    end

    always_comb begin
        mux_sel    = (sel_early && rx_word[BIT_WR]) ? rx_word[ADDR_HI:ADDR_LO] : reg_addr;
        range_sel  = reg_rng;
        coding_sel = reg_cod;
        pwr_mode   = reg_pm;
        pm_err     = reg_err;
    end
endmodule

// File: rtl/sadc_ctrl_port_chk.sv
module sadc_ctrl_port_chk
    import sadc_pkg::*;
#(
    parameter int CNT_W = $clog2(FRAME_LEN + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             dout_oe,
    input logic [1:0]       mux_sel,
    input logic [1:0]       pwr_mode,
    input logic             range_sel,
    input logic             coding_sel,
    input logic             powered,
    input logic             ready,
    input logic             wr_commit,
    input logic             frame_end,
    input logic [CNT_W-1:0] edge_cnt
);
    localparam logic [CNT_W-1:0] LO_EDGE = CNT_W'(MUX_EDGE - 1);
    localparam logic [CNT_W-1:0] HI_EDGE = CNT_W'(FRAME_LEN - 1);

    assert_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_commit) |-> ($stable(pwr_mode) && $stable(range_sel) && $stable(coding_sel)));

    assert_mux_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mux_sel) |-> ($past(edge_cnt) >= LO_EDGE && $past(edge_cnt) <= HI_EDGE));

    assert_oe_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |-> !dout_oe);

    assert_pm_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_mode != PM_BAD);

    assert_full_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode == PM_FULL && $past(pwr_mode) == PM_FULL && $past(pwr_mode, 2) == PM_FULL) |-> !powered);

    assert_auto_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(frame_end) && $past(pwr_mode) == PM_AUTO && $past(ready)) |-> !powered);
endmodule

bind sadc_ctrl_port sadc_ctrl_port_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .dout_oe    (dout_oe),
    .mux_sel    (mux_sel),
    .pwr_mode   (pwr_mode),
    .range_sel  (range_sel),
    .coding_sel (coding_sel),
    .powered    (powered),
    .ready      (ready),
    .wr_commit  (wr_commit),
    .frame_end  (frame_end),
    .edge_cnt   (edge_cnt)
);

// File: tb/sadc_ctrl_port_tb.sv
module sadc_ctrl_port_tb;
    localparam int W = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b1;
    logic        din = 1'b0;
    logic [11:0] sample = '0;
    logic        dout, dout_oe, range_sel, coding_sel, pm_err, powered, ready;
    logic [1:0]  mux_sel, pwr_mode;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    logic [1:0] m_addr = 2'd0, m_pm = 2'b11;
    logic       m_rng = 1'b0, m_cod = 1'b0, m_err = 1'b0;

    always #10 clk = ~clk;

    sadc_ctrl_port #(.WAKE_CYC(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .sample(sample), .dout(dout), .dout_oe(dout_oe), .mux_sel(mux_sel),
        .range_sel(range_sel), .coding_sel(coding_sel), .pwr_mode(pwr_mode),
        .pm_err(pm_err), .powered(powered), .ready(ready)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    function automatic logic [11:0] mk(input logic wr, input logic [1:0] a, input logic [1:0] pm,
                                       input logic rng, input logic cod, input logic [4:0] junk);
        return {wr, junk[4], junk[3], junk[2], a, pm, junk[1], junk[0], rng, cod};
    endfunction

    function automatic logic [15:0] exp_frame(input logic [11:0] smp, input logic [1:0] a, input logic cod);
        logic [11:0] d;
        d = cod ? smp : (smp ^ 12'h800);
        return {2'b00, a, d};
    endfunction

    task automatic model(input logic [11:0] w);
        if (w[11]) begin
            m_addr = w[7:6];
            m_rng  = w[1];
            m_cod  = w[0];
            if (w[5:4] == 2'b00) m_err = 1'b1;
            else begin m_pm = w[5:4]; m_err = 1'b0; end
        end
    endtask

    task automatic run_frame(input logic [15:0] w, input int stop_at, input logic [11:0] smp,
                             output logic [15:0] got, output logic [1:0] m13, output logic [1:0] m14);
        sample = smp;
        got = '0;
        m13 = mux_sel;
        m14 = mux_sel;
        @(negedge clk) cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < 16; i++) begin
            if (i == stop_at) break;
            din = w[15-i];
            repeat (2) @(negedge clk);
            got[15-i] = dout;
            sclk = 1'b0;
            repeat (4) @(negedge clk);
            if (i == 12) m13 = mux_sel;
            if (i == 13) m14 = mux_sel;
            sclk = 1'b1;
            repeat (2) @(negedge clk);
        end
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic check_regs(input string req);
        check({req, " mux_sel"}, 32'(mux_sel), 32'(m_addr));
        check({req, " pwr_mode"}, 32'(pwr_mode), 32'(m_pm));
        check({req, " range_sel"}, 32'(range_sel), 32'(m_rng));
        check({req, " coding_sel"}, 32'(coding_sel), 32'(m_cod));
        check({req, " pm_err"}, 32'(pm_err), 32'(m_err));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog got=timeout exp=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] got, ew;
        logic [1:0]  m13, m14, old_a;
        logic [11:0] w, smp;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        check_regs("R1");
        check("R1 powered", 32'(powered), 1);
        check("R1 ready", 32'(ready), 1);
        check("R1 dout_oe", 32'(dout_oe), 0);

        // R4 R5 R6 R7 sweep over address, coding, samples
        for (int a = 0; a < 4; a++) begin
            for (int c = 0; c < 2; c++) begin
                for (int s = 0; s < 8; s++) begin
                    case (s)
                        0: smp = 12'h000;
                        1: smp = 12'hFFF;
                        2: smp = 12'h800;
                        3: smp = 12'h7FF;
                        default: smp = 12'((s * 523 + a * 97 + c * 1000) % 4096);
                    endcase
                    w = mk(1'b1, 2'(a), 2'b11, s[0], c[0], 5'(s * 7 + a));
                    ew = exp_frame(smp, m_addr, m_cod);
                    old_a = m_addr;
                    run_frame({w, 4'(s)}, 16, smp, got, m13, m14);
                    check("R6 R7 dout frame", 32'(got), 32'(ew));
                    check("R5 mux before 14th edge", 32'(m13), 32'(old_a));
                    check("R5 mux after 14th edge", 32'(m14), 32'(a));
                    model(w);
                    check_regs("R4");
                    check("R6 dout_oe idle", 32'(dout_oe), 0);
                end
            end
        end

        // R2 write bit clear: nothing changes
        w = mk(1'b0, 2'd1, 2'b10, ~m_rng, ~m_cod, 5'h1F);
        run_frame({w, 4'hF}, 16, 12'h123, got, m13, m14);
        check("R2 mux no switch", 32'(m14), 32'(m_addr));
        check_regs("R2");
        check("R2 powered", 32'(powered), 1);

        // R3 trailing bits ignored
        w = mk(1'b1, 2'd2, 2'b11, 1'b1, 1'b0, 5'h00);
        run_frame({w, 4'h0}, 16, 12'h456, got, m13, m14);
        model(w);
        check_regs("R3 tail0");
        run_frame({w, 4'hF}, 16, 12'h456, got, m13, m14);
        check("R3 tail1 dout", 32'(got), 32'(exp_frame(12'h456, 2'd2, 1'b0)));
        check_regs("R3 tail1");
        w = mk(1'b1, 2'd2, 2'b11, 1'b1, 1'b0, 5'h00);
        run_frame({w[11:1], 1'b1, 4'h0}, 16, 12'h456, got, m13, m14);
        model({w[11:1], 1'b1});
        check("R3 12th bit loads", 32'(coding_sel), 1);

        // R9 abort after 15 edges
        old_a = m_addr;
        w = mk(1'b1, 2'd0, 2'b10, 1'b0, 1'b0, 5'h00);
        run_frame({w, 4'h0}, 15, 12'h789, got, m13, m14);
        check("R9 mux shown early", 32'(m14), 32'(0));
        check("R9 mux reverted", 32'(mux_sel), 32'(old_a));
        check_regs("R9");
        check("R9 powered", 32'(powered), 1);

        // R8 illegal power code
        w = mk(1'b1, 2'd3, 2'b00, 1'b0, 1'b1, 5'h00);
        run_frame({w, 4'h0}, 16, 12'h321, got, m13, m14);
        model(w);
        check_regs("R8 bad code");
        check("R8 pm_err set", 32'(pm_err), 1);
        w = mk(1'b1, 2'd1, 2'b11, 1'b0, 1'b1, 5'h00);
        run_frame({w, 4'h0}, 16, 12'h321, got, m13, m14);
        model(w);
        check("R8 pm_err cleared", 32'(pm_err), 0);
        check_regs("R8 good code");

        // R10 full shutdown
        w = mk(1'b1, 2'd2, 2'b10, 1'b1, 1'b0, 5'h00);
        run_frame({w, 4'h0}, 16, 12'h111, got, m13, m14);
        model(w);
        check("R10 powered off", 32'(powered), 0);
        check("R10 not ready", 32'(ready), 0);
        w = mk(1'b0, 2'd0, 2'b11, 1'b0, 1'b1, 5'h00);
        run_frame({w, 4'h0}, 16, 12'h222, got, m13, m14);
        check("R10 dout while off", 32'(got), 32'(exp_frame(12'h222, 2'd2, 1'b0)));
        check_regs("R10 retained");
        check("R10 still off", 32'(powered), 0);
        w = mk(1'b1, 2'd2, 2'b11, 1'b1, 1'b0, 5'h00);
        run_frame({w, 4'h0}, 16, 12'h333, got, m13, m14);
        model(w);
        check("R10 waking powered", 32'(powered), 1);
        check("R10 waking not ready", 32'(ready), 0);
        repeat (W + 2) @(negedge clk);
        check("R10 ready after wake", 32'(ready), 1);

        // R11 auto shutdown
        w = mk(1'b1, 2'd1, 2'b01, 1'b0, 1'b0, 5'h00);
        run_frame({w, 4'h0}, 16, 12'h444, got, m13, m14);
        model(w);
        check("R11 on after mode write", 32'(powered), 1);
        w = mk(1'b0, 2'd0, 2'b00, 1'b0, 1'b0, 5'h00);
        run_frame({w, 4'h0}, 16, 12'h555, got, m13, m14);
        check("R11 off after frame", 32'(powered), 0);
        @(negedge clk) cs_n = 1'b0;
        repeat (W) @(negedge clk);
        check("R11 wake powered", 32'(powered), 1);
        check("R11 not ready at W", 32'(ready), 0);
        @(negedge clk);
        check("R11 ready at W+1", 32'(ready), 1);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R11 stays on without frame end", 32'(powered), 1);
        check_regs("R11");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule